// File: doc/BRIEF.md
# Packed Multiply, Average and SAD Unit

This block is a lane-parallel integer arithmetic unit for media and signal kernels. Every cycle it can take two packed operands and an operation code, and it returns one packed result. It supports three per-lane 16-bit multiplies: low half, signed high half and unsigned high half. It also offers a signed multiply that sums each adjacent pair of word products into a 32-bit lane. A full 64-bit unsigned product is available from the low 32-bit lanes of the operands. The remaining operations are a rounded unsigned average of bytes or of words, and a sum of absolute byte differences that reduces the whole operand to one scalar.

The unit has two pipeline stages and no stall path. In stage one the per-lane products, averages and absolute differences are computed and packed into one payload register. In stage two that payload is reduced or selected into the result. A new operation may enter in every cycle. Its result appears with the output valid flag exactly two clock edges after it was accepted. Saturating arithmetic, shifts and floating point are handled elsewhere.

Top module: `pk_mas_unit`

## Requirements
- R1: Op code 0 puts, in each 16-bit lane, the low 16 bits of the product of the matching operand lanes.
- R2: Op code 1 puts, in each 16-bit lane, bits 31:16 of the signed (two's complement) 16×16 product of the matching lanes.
- R3: Op code 2 puts, in each 16-bit lane, bits 31:16 of the unsigned 16×16 product of the matching lanes.
- R4: Op code 3 forms signed 16×16 products per lane. It then writes, into 32-bit lane j, the sum of the products of 16-bit lanes 2j and 2j+1, kept modulo 2^32.
- R5: Op code 4 returns the full 64-bit unsigned product of bits 31:0 of both operands. Bits above 31 of the operands have no effect.
- R6: Op code 5 puts, in each 8-bit lane, (a + b + 1) >> 1 of the unsigned lanes, computed without losing the carry.
- R7: Op code 6 puts, in each 16-bit lane, (a + b + 1) >> 1 of the unsigned lanes, computed without losing the carry.
- R8: Op code 7 sums |a − b| over all unsigned 8-bit lanes into result bits 15:0, and all higher result bits are zero.
- R9: A result is presented with out_valid high exactly two rising edges after the edge that accepted in_valid. Back-to-back inputs give back-to-back results in order.
- R10: While rst is high, and after it is released, out_valid stays low unless an input was accepted two edges earlier. Inputs offered while rst is high produce no result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered this cycle |
| in_op | input | 3 | Operation code (0..7, see requirements) |
| in_a | input | 64 | First packed operand |
| in_b | input | 64 | Second packed operand |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Packed result |

## Verification
The hardest cases to reach are those where lane arithmetic crosses its natural width. Every word of both operands at the most negative value makes each multiply-add pair sum to exactly 2^31, which must wrap into the sign bit. All-ones bytes must not lose the carry in the average. Garbage in the upper half must not leak into the wide product. The stimulus drives these patterns directly and interleaves them back to back with other op codes, so that the stage-one payload register changes meaning on every cycle. A long stream of pseudo-random operands, op codes and idle gaps then runs through the scoreboard, which checks every result at its exact expected cycle.

// File: rtl/pk_mas_pkg.sv
package pk_mas_pkg;

   typedef enum logic [2:0] {
      OP_MUL_LO   = 3'd0,
      OP_MUL_HI_S = 3'd1,
      OP_MUL_HI_U = 3'd2,
      OP_MADD     = 3'd3,
      OP_MUL_WIDE = 3'd4,
      OP_AVG_B    = 3'd5,
      OP_AVG_W    = 3'd6,
      OP_SAD      = 3'd7
   } op_e;

   localparam int unsigned WIDE_IN_W  = 32;
   localparam int unsigned WIDE_OUT_W = 64;
   localparam int unsigned SAD_OUT_W  = 16;

endpackage

// File: rtl/pk_mas_mul_lanes.sv
// One 16x16 multiplier per lane; the sign-or-zero extension picks signed or unsigned.
module pk_mas_mul_lanes #(
   parameter int unsigned LANES = 4
) (
   input  logic [LANES*16-1:0] a,
   input  logic [LANES*16-1:0] b,
   input  logic                signed_mode,
   output logic [LANES*32-1:0] prod
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic        ext_a;
      logic        ext_b;
      logic [31:0] xa;
      logic [31:0] xb;
      assign ext_a = signed_mode & a[i*16+15];
      assign ext_b = signed_mode & b[i*16+15];
      assign xa    = {{16{ext_a}}, a[i*16 +: 16]};
      assign xb    = {{16{ext_b}}, b[i*16 +: 16]};
      assign prod[i*32 +: 32] = xa * xb;
   end

endmodule

// File: rtl/pk_mas_avg_lanes.sv
// Rounding-up average of unsigned bytes or words.
module pk_mas_avg_lanes #(
   parameter int unsigned DATA_W = 64
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              word_mode,
   output logic [DATA_W-1:0] result
);

   localparam int unsigned NB = DATA_W / 8;
   localparam int unsigned NW = DATA_W / 16;

   logic [DATA_W-1:0] res_b;
   logic [DATA_W-1:0] res_w;

   for (genvar i = 0; i < NB; i++) begin : g_byte
      logic [7:0] ab;
      logic [7:0] bb;
      assign ab = a[i*8 +: 8];
      assign bb = b[i*8 +: 8];
      assign res_b[i*8 +: 8] = 8'(({1'b0, ab} + {1'b0, bb} + 9'd1) >> 1);

      always_comb begin
         assert_avg_bounded_R6: assert (res_b[i*8 +: 8] >= ((ab < bb) ? ab : bb) &&
                                        res_b[i*8 +: 8] <= ((ab > bb) ? ab : bb));
      end
   end

   for (genvar i = 0; i < NW; i++) begin : g_word
      logic [15:0] aw;
      logic [15:0] bw;
      assign aw = a[i*16 +: 16];
      assign bw = b[i*16 +: 16];
      assign res_w[i*16 +: 16] = 16'(({1'b0, aw} + {1'b0, bw} + 17'd1) >> 1);

      always_comb begin
         assert_avg_bounded_R7: assert (res_w[i*16 +: 16] >= ((aw < bw) ? aw : bw) &&
                                        res_w[i*16 +: 16] <= ((aw > bw) ? aw : bw));
      end
   end

   assign result = word_mode ? res_w : res_b;

endmodule

// File: rtl/pk_mas_absdiff.sv
// Per-byte unsigned absolute difference.
module pk_mas_absdiff #(
   parameter int unsigned DATA_W = 64
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] diff
);

   localparam int unsigned NB = DATA_W / 8;

   for (genvar i = 0; i < NB; i++) begin : g_byte
      logic [7:0] ab;
      logic [7:0] bb;
      assign ab = a[i*8 +: 8];
      assign bb = b[i*8 +: 8];
      assign diff[i*8 +: 8] = (ab >= bb) ? (ab - bb) : (bb - ab);
   end

endmodule

// File: rtl/pk_mas_combine.sv
// Stage-two reduction and selection from the packed stage-one payload.
module pk_mas_combine
   import pk_mas_pkg::*;
#(
   parameter int unsigned DATA_W   = 64,
   parameter bit          SAD_TREE = 1'b1
) (
   input  op_e                 op,
   input  logic [2*DATA_W-1:0] data,
   output logic [DATA_W-1:0]   result
);

   localparam int unsigned NB = DATA_W / 8;
   localparam int unsigned NW = DATA_W / 16;
   localparam int unsigned ND = DATA_W / 32;
   localparam int unsigned SW = $clog2(NB * 255 + 1);

   logic [SW-1:0]     sad_sum;
   logic [DATA_W-1:0] lo_half;
   logic [DATA_W-1:0] hi_half;
   logic [DATA_W-1:0] pair_sum;

   for (genvar i = 0; i < NW; i++) begin : g_half
      assign lo_half[i*16 +: 16] = data[i*32 +: 16];
      assign hi_half[i*16 +: 16] = data[i*32+16 +: 16];
   end

   for (genvar j = 0; j < ND; j++) begin : g_pair
      assign pair_sum[j*32 +: 32] = data[(2*j)*32 +: 32] + data[(2*j+1)*32 +: 32];
   end

   if (SAD_TREE) begin : g_sad_tree
      logic [SW-1:0] node [2*NB-1];
      for (genvar i = 0; i < NB; i++) begin : g_leaf
         assign node[NB-1+i] = SW'(data[i*8 +: 8]);
      end
      for (genvar k = 0; k < NB - 1; k++) begin : g_node
         assign node[k] = node[2*k+1] + node[2*k+2];
      end
      assign sad_sum = node[0];
   end else begin : g_sad_chain
      always_comb begin
         sad_sum = '0;
         for (int i = 0; i < NB; i++) begin
            sad_sum = sad_sum + SW'(data[i*8 +: 8]);
         end
      end
   end

   always_comb begin
      result = '0;
      unique case (op)
         OP_MUL_LO:               result = lo_half;
         OP_MUL_HI_S, OP_MUL_HI_U: result = hi_half;
         OP_MADD:                 result = pair_sum;
         OP_SAD:                  result[SAD_OUT_W-1:0] = SAD_OUT_W'(sad_sum);
         default:                 result = data[DATA_W-1:0];
      endcase
   end

endmodule

// File: rtl/pk_mas_unit.sv
// Two-stage packed multiply / average / SAD unit.
module pk_mas_unit
   import pk_mas_pkg::*;
#(
   parameter int unsigned DATA_W   = 64,
   parameter bit          SAD_TREE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [2:0]        in_op,
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_result
);

   localparam int unsigned LANES16 = DATA_W / 16;
   localparam int unsigned NB      = DATA_W / 8;
   localparam int unsigned PAY_W   = 2 * DATA_W;

   if (DATA_W % 32 != 0 || DATA_W < WIDE_OUT_W) begin : g_bad_width
      $error("pk_mas_unit: DATA_W must be a multiple of 32 and at least 64");
   end
   if (NB * 255 > 65535) begin : g_bad_sad
      $error("pk_mas_unit: SAD sum does not fit the 16-bit result field");
   end
   if (SAD_TREE && ((NB & (NB - 1)) != 0)) begin : g_bad_tree
      $error("pk_mas_unit: tree SAD needs a power-of-two byte count");
   end

   op_e               op_in;
   logic              mul_signed;
   logic [PAY_W-1:0]  prod16;
   logic [DATA_W-1:0] avg_res;
   logic [DATA_W-1:0] abs_res;
   logic [WIDE_OUT_W-1:0] wide_prod;
   logic [PAY_W-1:0]  payload;

   logic              s1_valid;
   op_e               s1_op;
   logic [PAY_W-1:0]  s1_data;
   logic [DATA_W-1:0] comb_res;

   assign op_in      = op_e'(in_op);
   assign mul_signed = (op_in == OP_MUL_HI_S) || (op_in == OP_MADD);

   pk_mas_mul_lanes #(.LANES(LANES16)) u_mul (
      .a(in_a), .b(in_b), .signed_mode(mul_signed), .prod(prod16)
   );

   pk_mas_avg_lanes #(.DATA_W(DATA_W)) u_avg (
      .a(in_a), .b(in_b), .word_mode(op_in == OP_AVG_W), .result(avg_res)
   );

   pk_mas_absdiff #(.DATA_W(DATA_W)) u_abs (
      .a(in_a), .b(in_b), .diff(abs_res)
   );

   assign wide_prod = {32'b0, in_a[WIDE_IN_W-1:0]} * {32'b0, in_b[WIDE_IN_W-1:0]};

   always_comb begin
      payload = '0;
      unique case (op_in)
         OP_MUL_LO, OP_MUL_HI_S, OP_MUL_HI_U, OP_MADD: payload = prod16;
         OP_MUL_WIDE:        payload[WIDE_OUT_W-1:0] = wide_prod;
         OP_AVG_B, OP_AVG_W: payload[DATA_W-1:0] = avg_res;
         default:            payload[DATA_W-1:0] = abs_res;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_valid <= 1'b0;
      end else begin
         s1_valid <= in_valid;
      end
      if (in_valid) begin
         s1_op   <= op_in;
         s1_data <= payload;
      end
   end

   pk_mas_combine #(.DATA_W(DATA_W), .SAD_TREE(SAD_TREE)) u_comb (
      .op(s1_op), .data(s1_data), .result(comb_res)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
      end else begin
         out_valid <= s1_valid;
      end
      if (s1_valid) begin
         out_result <= comb_res;
      end
   end

   assert_stage1_R9: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> s1_valid);

   assert_stage2_R9: assert property (@(posedge clk) disable iff (rst)
      s1_valid |=> out_valid);

   assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
      !s1_valid |=> !out_valid);

   assert_sad_upper_R8: assert property (@(posedge clk) disable iff (rst)
      (s1_valid && s1_op == OP_SAD) |=> (out_result[DATA_W-1:SAD_OUT_W] == '0));

   assert_wide_zero_R5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_in == OP_MUL_WIDE && in_a[WIDE_IN_W-1:0] == '0)
      |=> (s1_data[WIDE_OUT_W-1:0] == '0));

endmodule

// File: tb/pk_mas_unit_bench.sv
module pk_mas_unit_bench;

   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [63:0] exp;
      int          stamp;
      logic [2:0]  op;
   } item_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [2:0]  in_op = '0;
   logic [63:0] in_a = '0;
   logic [63:0] in_b = '0;
   logic        out_valid;
   logic [63:0] out_result;

   int          cyc = 0;
   int          n_checks = 0;
   int          n_fails = 0;
   bit          done = 1'b0;
   logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;
   item_t       q[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pk_mas_unit u_pk_mas_unit (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
      .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result)
   );

   function automatic string req_tag(logic [2:0] op);
      case (op)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         3'd4: return "R5";
         3'd5: return "R6";
         3'd6: return "R7";
         default: return "R8";
      endcase
   endfunction

   // Reference model written from the requirements.
   function automatic logic [63:0] model(logic [2:0] op, logic [63:0] a, logic [63:0] b);
      logic [63:0] r = '0;
      case (op)
         3'd0, 3'd1, 3'd2: begin
            for (int i = 0; i < 4; i++) begin
               longint x, y, p;
               if (op == 3'd2) begin
                  x = longint'(a[i*16 +: 16]);
                  y = longint'(b[i*16 +: 16]);
               end else begin
                  x = longint'($signed(a[i*16 +: 16]));
                  y = longint'($signed(b[i*16 +: 16]));
               end
               p = x * y;
               r[i*16 +: 16] = (op == 3'd0) ? p[15:0] : p[31:16];
            end
         end
         3'd3: begin
            for (int j = 0; j < 2; j++) begin
               longint s = 0;
               for (int k = 0; k < 2; k++) begin
                  s += longint'($signed(a[(2*j+k)*16 +: 16])) *
                       longint'($signed(b[(2*j+k)*16 +: 16]));
               end
               r[j*32 +: 32] = s[31:0];
            end
         end
         3'd4: r = {32'b0, a[31:0]} * {32'b0, b[31:0]};
         3'd5: begin
            for (int i = 0; i < 8; i++) begin
               int s = int'(a[i*8 +: 8]) + int'(b[i*8 +: 8]) + 1;
               r[i*8 +: 8] = 8'(s >>> 1);
            end
         end
         3'd6: begin
            for (int i = 0; i < 4; i++) begin
               int s = int'(a[i*16 +: 16]) + int'(b[i*16 +: 16]) + 1;
               r[i*16 +: 16] = 16'(s >>> 1);
            end
         end
         default: begin
            int acc = 0;
            for (int i = 0; i < 8; i++) begin
               int x = int'(a[i*8 +: 8]);
               int y = int'(b[i*8 +: 8]);
               acc += (x > y) ? (x - y) : (y - x);
            end
            r[15:0] = 16'(acc);
         end
      endcase
      return r;
   endfunction

   function automatic logic [63:0] rnd64();
      seed ^= seed << 13;
      seed ^= seed >> 7;
      seed ^= seed << 17;
      return seed;
   endfunction

   task automatic send(logic [2:0] op, logic [63:0] a, logic [63:0] b);
      item_t it;
      @(negedge clk);
      in_valid = 1'b1;
      in_op    = op;
      in_a     = a;
      in_b     = b;
      it.exp   = model(op, a, b);
      it.stamp = cyc + 2;
      it.op    = op;
      q.push_back(it);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_a     = rnd64();
         in_b     = rnd64();
      end
   endtask

   // Scoreboard monitor.
   always @(negedge clk) begin
      item_t it;
      if (!rst) begin
         if (q.size() > 0 && q[0].stamp == cyc) begin
            it = q.pop_front();
            n_checks++;
            if (!out_valid || out_result !== it.exp) begin
               n_fails++;
               $display("FAIL %s/R9 op=%0d valid=%b got %h expected %h",
                        req_tag(it.op), it.op, out_valid, out_result, it.exp);
            end
         end else if (out_valid) begin
            n_checks++;
            n_fails++;
            $display("FAIL R10 unexpected out_valid got 1 expected 0 at cycle %0d", cyc);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog expired got running expected finished");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      // R10: inputs offered during reset yield nothing.
      in_valid = 1'b1;
      in_op    = 3'd7;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         n_checks++;
         if (out_valid !== 1'b0) begin
            n_fails++;
            $display("FAIL R10 out_valid in reset got %b expected 0", out_valid);
         end
      end
      in_valid = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      idle(3);

      // R1..R3 corner multiplies
      send(3'd0, 64'h7FFF_8000_FFFF_1234, 64'h0002_0002_FFFF_0010);
      send(3'd1, 64'hFFFF_8000_7FFF_8000, 64'hFFFF_8000_7FFF_7FFF);
      send(3'd2, 64'hFFFF_8000_7FFF_0001, 64'hFFFF_8000_FFFF_FFFF);
      send(3'd1, 64'h0003_FFFD_1234_0000, 64'hFFFE_0007_5678_ABCD);
      // R4: pair sums that wrap into the sign bit
      send(3'd3, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000);
      send(3'd3, 64'h7FFF_8000_0002_FFFF, 64'h7FFF_7FFF_0003_0005);
      // R5: operand upper halves carry garbage
      send(3'd4, 64'hDEAD_BEEF_FFFF_FFFF, 64'h1234_5678_FFFF_FFFF);
      send(3'd4, 64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_1234_5678);
      // R6, R7: carry must survive
      send(3'd5, 64'hFF00_FF01_8081_0000, 64'hFFFF_0001_7F80_0000);
      send(3'd6, 64'hFFFF_0000_FFFF_8000, 64'hFFFF_FFFF_0000_7FFF);
      // R8: largest and mixed sums
      send(3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000);
      send(3'd7, 64'h0010_2030_4050_6070, 64'h7060_5040_3020_1000);
      send(3'd7, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0);
      idle(4);

      // R9: long back-to-back stream with sporadic gaps
      for (int n = 0; n < 1500; n++) begin
         logic [63:0] ra = rnd64();
         logic [63:0] rb = rnd64();
         logic [63:0] sel = rnd64();
         if (sel[5:3] == 3'd0) ra = 64'h8000_8000_8000_8000;
         if (sel[8:6] == 3'd0) rb = '1;
         send(sel[2:0], ra, rb);
         if (sel[12:9] == 4'd0) idle(int'(sel[14:13]) + 1);
      end
      idle(6);

      n_checks++;
      if (q.size() != 0) begin
         n_fails++;
         $display("FAIL R9 pending results got %0d expected 0", q.size());
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule